// File: doc/BRIEF.md
# Bidirectional Cascaded Display-Row Capture

This block is the input stage of a display column driver. Display data arrives as 36-bit words, each holding six 6-bit gray values, and one word is taken per clock. The words go into a register as wide as the row, which is passed on to a later latch stage. Several drivers are chained. Each one waits for a start pulse on its input start pin, fills its row, and then sends a one-clock start pulse to the next driver in the chain.

A direction select decides two things: which of the two bidirectional start pins acts as the input, and whether filling begins at the first output or the last. A narrow mode shortens the row from 402 to 384 outputs by leaving out the middle columns 193 to 210. Two inversion controls can each complement one half of every word as it is loaded. After the last word plus two clocks of overlap, capture stops by itself. A strobe rising edge ends capture at any time. The narrow-mode select should be tied high when no other choice is made.

Top module: `disp_capture`

## Requirements
- R1: After reset every row bit is 0, the output start pin is low, and no data is stored until a start pulse is recognised.
- R2: Each clock after a recognised start stores one word. Dot d (bits 6d+5..6d, bit 0 = LSB) of a word goes to the d-th output of its six-output group, and output n (1-based) appears at row_o[6(n-1)+5 : 6(n-1)]. The word present at the start edge itself is not stored.
- R3: With dir_i = 1, start_r_io is the start input, word j fills group j counting upward from output 1, and start_l_io carries the cascade pulse. With dir_i = 0 the two pins swap roles and word j fills group 66-j, counting downward from output 402.
- R4: A start is recognised when the input start pin is high at a clock edge after being low at the previous edge. If it stays high for further clocks, those clocks are ordinary data clocks.
- R5: The output start pin is high for exactly one clock. It rises just after the edge that stores the last word: the 67th data clock in full mode, the 64th in narrow mode.
- R6: The capture window lasts 69 clocks after the start (66 in narrow mode). Data after the last word is never stored, and the row holds its contents until a new start.
- R7: With narrow_i = 1, 64 words are stored and groups 32..34 (outputs 193..210) are skipped in both directions, so they keep their earlier contents.
- R8: When inv_lo_i = 1, dots 0..2 of each stored word are complemented. When inv_hi_i = 1, dots 3..5 are complemented. The controls are sampled at the clock that stores the word.
- R9: A rising edge on strobe_i ends capture: later words are ignored until a new start. Keeping strobe high has no further effect. A strobe rise wins over a start pulse recognised at the same edge.
- R10: A new start recognised during a capture restarts filling at the first position of the current direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | 1: fill upward, right pin is input; 0: mirrored |
| narrow_i | input | 1 | 1: 384-output mode skipping the middle groups |
| inv_lo_i | input | 1 | Complement dots 0..2 of each loaded word |
| inv_hi_i | input | 1 | Complement dots 3..5 of each loaded word |
| strobe_i | input | 1 | Rising edge ends capture |
| data_i | input | 36 | Six 6-bit gray values per clock |
| start_r_io | inout | 1 | Start input when dir_i = 1, cascade output otherwise |
| start_l_io | inout | 1 | Cascade output when dir_i = 1, start input otherwise |
| row_o | output | 2412 | Captured row, six bits per output |

## Verification
The bench targets the exact clock at which the cascade pulse fires in each mode. A counter that is off by one would show up either as a pulse that is early or late compared with the model, or as the last word landing in the wrong group. It also holds the start pin high for several clocks: a design that re-arms on level rather than edge would keep overwriting group 0. The narrow runs in both directions check that the middle groups keep their old contents, which catches a wrong gap mapping as corruption in outputs 193 to 210. Strobe in the middle of a line, strobe together with start, and a restart in the middle of a line check that the state machine drops the line or rewinds it, instead of carrying on with the old position.

// File: rtl/capture_pkg.sv
`timescale 1ns/1ps
package capture_pkg;
  localparam int unsigned CP_DOT_W        = 6;
  localparam int unsigned CP_DOTS         = 6;
  localparam int unsigned CP_SLOTS_FULL   = 67;
  localparam int unsigned CP_SLOTS_NARROW = 64;
  localparam int unsigned CP_GAP_FIRST    = 32;
  localparam int unsigned CP_HALT_TAIL    = 2;

  typedef enum logic {
    FILL_DESCEND = 1'b0,
    FILL_ASCEND  = 1'b1
  } fill_dir_e;
endpackage

// File: rtl/capture_invert.sv
`timescale 1ns/1ps
module capture_invert #(
  parameter int unsigned DOT_W = 6,
  parameter int unsigned DOTS  = 6
) (
  input  logic                    inv_lo_i,
  input  logic                    inv_hi_i,
  input  logic [DOT_W*DOTS-1:0]   word_i,
  output logic [DOT_W*DOTS-1:0]   word_o
);
  localparam int unsigned HALF = DOTS / 2;

  for (genvar d = 0; d < DOTS; d++) begin : g_dot
    localparam bit UPPER = (d >= HALF);
    logic flip;
    assign flip = UPPER ? inv_hi_i : inv_lo_i;
    assign word_o[d*DOT_W +: DOT_W] = word_i[d*DOT_W +: DOT_W] ^ {DOT_W{flip}};
  end
endmodule

// File: rtl/capture_seq.sv
`timescale 1ns/1ps
module capture_seq
  import capture_pkg::*;
#(
  parameter int unsigned SLOTS        = CP_SLOTS_FULL,
  parameter int unsigned SLOTS_NARROW = CP_SLOTS_NARROW,
  parameter int unsigned GAP_FIRST    = CP_GAP_FIRST,
  parameter int unsigned HALT_TAIL    = CP_HALT_TAIL
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start_raw_i,
  input  logic                                    strobe_i,
  input  logic                                    narrow_i,
  input  logic                                    dir_i,
  output logic                                    wr_en_o,
  output logic [$clog2(SLOTS)-1:0]                slot_o,
  output logic                                    casc_o,
  output logic                                    active_o,
  output logic [$clog2(SLOTS+HALT_TAIL+1)-1:0]    cnt_o
);
  localparam int unsigned SW    = $clog2(SLOTS);
  localparam int unsigned CW    = $clog2(SLOTS + HALT_TAIL + 1);
  localparam int unsigned GAP_N = SLOTS - SLOTS_NARROW;
  localparam logic [CW-1:0] WORDS_F = CW'(SLOTS);
  localparam logic [CW-1:0] WORDS_N = CW'(SLOTS_NARROW);
  localparam logic [CW-1:0] TAIL    = CW'(HALT_TAIL);
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] GAPF    = CW'(GAP_FIRST);
  localparam logic [CW-1:0] GAPN    = CW'(GAP_N);
  localparam logic [CW-1:0] LASTS   = CW'(SLOTS - 1);

  logic          strb_q, strt_q, casc_q, active_q;
  logic [CW-1:0] cnt_q;
  logic          active_d, casc_d, run_en, strb_rise, strt_rise, wr_en;
  logic [CW-1:0] cnt_d, words, last, word_idx, logical, placed;

  always_comb begin
    words     = narrow_i ? WORDS_N : WORDS_F;
    last      = words + TAIL;
    strb_rise = strobe_i & ~strb_q;
    strt_rise = start_raw_i & ~strt_q;
    active_d  = active_q;
    cnt_d     = cnt_q;
    casc_d    = 1'b0;
    wr_en     = 1'b0;
    run_en    = 1'b0;
    if (strb_rise) begin
      active_d = 1'b0;
      cnt_d    = '0;
      run_en   = 1'b1;
    end else if (strt_rise) begin
      active_d = 1'b1;
      cnt_d    = ONE;
      run_en   = 1'b1;
    end else if (active_q) begin
      run_en = 1'b1;
      wr_en  = (cnt_q <= words);
      casc_d = (cnt_q == words);
      if (cnt_q == last) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
    word_idx = cnt_q - ONE;
    logical  = (narrow_i && (word_idx >= GAPF)) ? word_idx + GAPN : word_idx;
    placed   = (fill_dir_e'(dir_i) == FILL_ASCEND) ? logical : LASTS - logical;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      strt_q   <= 1'b0;
      casc_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strb_q <= strobe_i;
      strt_q <= start_raw_i;
      casc_q <= casc_d;
      if (run_en) begin
        active_q <= active_d;
        cnt_q    <= cnt_d;
      end
    end
  end

  assign wr_en_o  = wr_en;
  assign slot_o   = placed[SW-1:0];
  assign casc_o   = casc_q;
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/disp_capture.sv
`timescale 1ns/1ps
module disp_capture
  import capture_pkg::*;
#(
  parameter int unsigned DOT_W        = CP_DOT_W,
  parameter int unsigned DOTS         = CP_DOTS,
  parameter int unsigned SLOTS        = CP_SLOTS_FULL,
  parameter int unsigned SLOTS_NARROW = CP_SLOTS_NARROW,
  parameter int unsigned GAP_FIRST    = CP_GAP_FIRST,
  parameter int unsigned HALT_TAIL    = CP_HALT_TAIL
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dir_i,
  input  logic                          narrow_i,
  input  logic                          inv_lo_i,
  input  logic                          inv_hi_i,
  input  logic                          strobe_i,
  input  logic [DOT_W*DOTS-1:0]         data_i,
  inout  wire                           start_r_io,
  inout  wire                           start_l_io,
  output logic [SLOTS*DOT_W*DOTS-1:0]   row_o
);
  localparam int unsigned WORD_W = DOT_W * DOTS;
  localparam int unsigned SW     = $clog2(SLOTS);
  localparam int unsigned CW     = $clog2(SLOTS + HALT_TAIL + 1);

  logic              start_raw, casc, wr_en, active;
  logic [SW-1:0]     slot;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] word_ld;

  // The pin that is not the input carries the cascade pulse.
  assign start_r_io = dir_i ? 1'bz : casc;
  assign start_l_io = dir_i ? casc : 1'bz;
  assign start_raw  = dir_i ? start_r_io : start_l_io;

  capture_seq #(
    .SLOTS(SLOTS), .SLOTS_NARROW(SLOTS_NARROW),
    .GAP_FIRST(GAP_FIRST), .HALT_TAIL(HALT_TAIL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_raw_i(start_raw), .strobe_i(strobe_i),
    .narrow_i(narrow_i), .dir_i(dir_i), .wr_en_o(wr_en), .slot_o(slot),
    .casc_o(casc), .active_o(active), .cnt_o(cnt)
  );

  capture_invert #(.DOT_W(DOT_W), .DOTS(DOTS)) u_inv (
    .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i), .word_i(data_i), .word_o(word_ld)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] grp_q;
    logic              grp_en;
    assign grp_en = wr_en && (slot == SW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      grp_q <= '0;
      else if (grp_en) grp_q <= word_ld;
    end
    assign row_o[s*WORD_W +: WORD_W] = grp_q;
  end
endmodule

// File: rtl/capture_chk.sv
`timescale 1ns/1ps
module capture_chk #(
  parameter int unsigned SLOTS        = 67,
  parameter int unsigned SLOTS_NARROW = 64,
  parameter int unsigned GAP_FIRST    = 32,
  parameter int unsigned HALT_TAIL    = 2,
  parameter int unsigned SW           = 7,
  parameter int unsigned CW           = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_i,
  input logic          narrow_i,
  input logic          start_raw,
  input logic          active,
  input logic [CW-1:0] cnt,
  input logic          wr_en,
  input logic [SW-1:0] slot,
  input logic          casc
);
  localparam logic [CW-1:0] WF   = CW'(SLOTS);
  localparam logic [CW-1:0] WN   = CW'(SLOTS_NARROW);
  localparam logic [CW-1:0] TAIL = CW'(HALT_TAIL);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [SW-1:0] G_LO = SW'(GAP_FIRST);
  localparam logic [SW-1:0] G_HI = SW'(GAP_FIRST + SLOTS - SLOTS_NARROW);

  logic          strb_p, strt_p;
  logic [CW-1:0] cnt_p, words;
  assign words = narrow_i ? WN : WF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_p <= 1'b0;
      strt_p <= 1'b0;
      cnt_p  <= '0;
    end else begin
      strb_p <= strobe_i;
      strt_p <= start_raw;
      cnt_p  <= cnt;
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_raw && !strt_p && !(strobe_i && !strb_p)) |=> (active && cnt == ONE)); // R4
  AST_STROBE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !strb_p) |=> !active); // R9
  AST_CASC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    casc |=> !casc); // R5
  AST_CASC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    casc |-> (cnt_p == words)); // R5
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (active && cnt != '0 && cnt <= words)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= words + TAIL)); // R6
  AST_NARROW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_i && wr_en) |-> (slot < G_LO || slot >= G_HI)); // R7
endmodule

bind disp_capture capture_chk #(
  .SLOTS(SLOTS), .SLOTS_NARROW(SLOTS_NARROW), .GAP_FIRST(GAP_FIRST),
  .HALT_TAIL(HALT_TAIL), .SW(SW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .narrow_i(narrow_i),
  .start_raw(start_raw), .active(active), .cnt(cnt), .wr_en(wr_en),
  .slot(slot), .casc(casc)
);

// File: tb/test_disp_capture.sv
`timescale 1ns/1ps
module test_disp_capture;
  localparam int SLOTS = 67, NARROW = 64, DOTS = 6, OUTS = SLOTS * DOTS;
  localparam int WW = 36, RW = SLOTS * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic dir = 1'b1, narrow = 1'b0, inv_lo = 1'b0, inv_hi = 1'b0;
  logic strobe = 1'b0, tb_start = 1'b0;
  logic [WW-1:0] data = '0;
  logic [RW-1:0] row;
  wire start_r, start_l;

  assign start_r = dir ? tb_start : 1'bz;
  assign start_l = dir ? 1'bz : tb_start;

  disp_capture i_disp_capture (
    .clk(clk), .rst_n(rst_n), .dir_i(dir), .narrow_i(narrow), .inv_lo_i(inv_lo),
    .inv_hi_i(inv_hi), .strobe_i(strobe), .data_i(data),
    .start_r_io(start_r), .start_l_io(start_l), .row_o(row)
  );

  int checks = 0, fails = 0;
  logic [5:0] ref_row [OUTS];
  bit m_active = 0, m_strb_q = 0, m_strt_q = 0, m_casc = 0;
  int m_k = 0;

  // Group for the j-th stored word: walk the valid groups in fill order.
  function automatic int slot_of(int j, bit nar, bit up);
    int seen = 0;
    int hit = -1;
    for (int s = 0; s < SLOTS; s++) begin
      bit gap = nar && (s * DOTS >= 192) && (s * DOTS < 210);
      if (!gap) begin
        if (seen == j) hit = s;
        seen++;
      end
    end
    return up ? hit : SLOTS - 1 - hit;
  endfunction

  task automatic model_edge();
    int words = narrow ? NARROW : SLOTS;
    bit rs = strobe && !m_strb_q;
    bit rt = tb_start && !m_strt_q;
    bit cn = 0;
    int sl;
    logic [5:0] v;
    if (rs) m_active = 0;
    else if (rt) begin m_active = 1; m_k = 1; end
    else if (m_active) begin
      if (m_k <= words) begin
        sl = slot_of(m_k - 1, narrow, dir);
        for (int d = 0; d < DOTS; d++) begin
          v = data[d*6 +: 6];
          if ((d < 3 && inv_lo) || (d >= 3 && inv_hi)) v = ~v;
          ref_row[sl*DOTS + d] = v;
        end
      end
      if (m_k == words) cn = 1;
      if (m_k == words + 2) m_active = 0;
      else m_k++;
    end
    m_casc = cn;
    m_strb_q = strobe;
    m_strt_q = tb_start;
  endtask

  task automatic compare(string tag);
    int bad = -1;
    logic got;
    for (int n = 0; n < OUTS; n++)
      if (bad < 0 && row[n*6 +: 6] !== ref_row[n]) bad = n;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: output %0d got %h expected %h", tag, bad + 1,
               row[bad*6 +: 6], ref_row[bad]);
    end
    got = dir ? start_l : start_r;
    checks++;
    if (got !== m_casc) begin
      fails++;
      $display("FAIL %s: cascade pin got %b expected %b", tag, got, m_casc);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_words(int n, string tag);
    for (int i = 0; i < n; i++) begin
      data = WW'({$urandom, $urandom});
      tick(tag);
    end
  endtask

  task automatic pulse_start(string tag);
    tb_start = 1'b1;
    data = WW'({$urandom, $urandom});
    tick(tag);
    tb_start = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < OUTS; n++) ref_row[n] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    run_words(4, "R1 idle ignores data");

    // Full width, upward, plain data, run past the halt point.
    pulse_start("R2 start edge not stored");
    run_words(74, "R2 R3 R5 R6 upward full line");

    // Strobe in mid-line, held high for a few clocks.
    pulse_start("R9 start before strobe");
    run_words(20, "R9 partial line");
    strobe = 1'b1;
    run_words(3, "R9 strobe held");
    strobe = 1'b0;
    run_words(8, "R9 data after strobe ignored");

    // Downward, low half inverted, start held for three clocks.
    dir = 1'b0;
    inv_lo = 1'b1;
    run_words(2, "R3 direction swap idle");
    tb_start = 1'b1;
    run_words(3, "R4 held start counts once");
    tb_start = 1'b0;
    run_words(70, "R3 R5 R8 downward full line");

    // Narrow, upward, high half inverted.
    dir = 1'b1; narrow = 1'b1; inv_lo = 1'b0; inv_hi = 1'b1;
    run_words(2, "R7 mode change idle");
    pulse_start("R7 narrow start");
    run_words(70, "R5 R7 R8 narrow upward");

    // Narrow, downward, both halves inverted.
    dir = 1'b0; inv_lo = 1'b1;
    run_words(2, "R7 idle");
    pulse_start("R7 narrow start down");
    run_words(70, "R6 R7 R8 narrow downward");

    // Restart in the middle of a line.
    dir = 1'b1; narrow = 1'b0; inv_lo = 1'b0; inv_hi = 1'b0;
    run_words(2, "R10 idle");
    pulse_start("R10 first start");
    run_words(10, "R10 before restart");
    pulse_start("R10 restart edge");
    run_words(72, "R10 R5 line after restart");

    // Strobe and start recognised at the same edge.
    pulse_start("R9 start");
    run_words(5, "R9 few words");
    strobe = 1'b1; tb_start = 1'b1;
    run_words(1, "R9 strobe beats start");
    strobe = 1'b0; tb_start = 1'b0;
    run_words(6, "R9 nothing stored after");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule